// File: doc/BRIEF.md
# Chained Dual-Wiper Potentiometer Serial Writer

This block programs a chain of daisy-chained dual-wiper digital potentiometers from the host side. The interface has three wires: an enable, a serial clock and a serial data line. One more input carries the bit that comes back from the far end of the chain. Each device in the chain holds a 17-bit frame made of a stack-select bit, an 8-bit wiper-1 code and an 8-bit wiper-0 code. The devices are wired in series, so the chain as a whole behaves as one long shift register.

A one-cycle start request loads the settings for every device from a flat input vector. The block then raises enable and clocks out exactly `NUM_DEV*17` bits, most significant bit first, with the farthest device's frame sent first. After that it lowers enable and pulses done. The bits that return from the chain are captured at the same time, so the settings the chain held before the transaction can be read back when done is seen.

The serial clock is the system clock divided by `DIV_RATIO`. Elaboration stops with an error if the resulting serial rate would exceed `MAX_SCLK_HZ`.

The sequencer has five states:
- `ST_IDLE`: enable is low and the block waits for a start.
- `ST_SETUP`: enable is high and the serial clock is low for the setup half period.
- `ST_HIGH`: the serial clock is high.
- `ST_LOW`: the serial clock is low between bits.
- `ST_HOLD`: the serial clock is low for the final half period before enable drops.

The transitions are:
- start: `ST_IDLE` to `ST_SETUP`.
- setup-done: `ST_SETUP` to `ST_HIGH`.
- next-bit: `ST_HIGH` to `ST_LOW`.
- rise: `ST_LOW` to `ST_HIGH`.
- last-bit: `ST_HIGH` to `ST_HOLD`, taken once all bits have risen.
- finish: `ST_HOLD` to `ST_IDLE`.

Every transition except start happens on a half-period tick.

Top module: `chain_pot_writer`

## Requirements
- R1: Device k takes its settings from `cfg_i[17k+16:17k]`. Bit 17k+16 is the stack-select bit, bits 17k+15..17k+8 are the wiper-1 code and bits 17k+7..17k are the wiper-0 code. Each frame goes out in the order stack-select, then wiper 1 MSB first, then wiper 0 MSB first.
- R2: The whole stream is sent MSB first, starting at bit `NUM_DEV*17-1`, so the frame for the farthest device (index `NUM_DEV-1`) leaves first. After the transaction, each device k holds field k.
- R3: Each transaction has exactly `NUM_DEV*17` rising edges of `sclk_o`, never a partial frame.
- R4: `sdat_o` changes only in the cycle where `sclk_o` falls, or when `sen_o` rises. It is stable while `sclk_o` is high, and `sret_i` is sampled on the system clock edge that raises `sclk_o`.
- R5: `sclk_o` is high for `DIV_RATIO/2` system cycles and low for `DIV_RATIO/2` cycles between rises. Elaboration rejects a `DIV_RATIO` that is odd, below 2, or gives a rate above `MAX_SCLK_HZ`.
- R6: `sen_o` rises `DIV_RATIO/2` cycles before the first rising edge of `sclk_o` and falls `DIV_RATIO/2` cycles after the last falling edge. `sclk_o` is low whenever `sen_o` is low.
- R7: `busy_o` is high from the cycle after an accepted start until `sen_o` falls. `done_o` is a one-cycle pulse in the cycle `sen_o` falls. A start while busy is ignored, and so is a change of `cfg_i` while busy.
- R8: When `done_o` is high, `rdback_o` field k (same layout as R1) equals the frame device k held before the transaction.
- R9: In reset, and while idle after reset, `sen_o`, `sclk_o`, `sdat_o`, `busy_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| cfg_i | input | NUM_DEV*17 | Per-device settings, laid out as in R1 |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rdback_o | output | NUM_DEV*17 | Previous chain contents, laid out as in R1 |
| sen_o | output | 1 | Serial enable to the chain |
| sclk_o | output | 1 | Serial clock to the chain |
| sdat_o | output | 1 | Serial data to the first device |
| sret_i | input | 1 | Serial data returned from the last device |

## Verification
The end of one transaction and the start of the next can fall in the same cycle. A start presented during the cycle `done_o` is high must be accepted, with `busy_o` high in the next cycle and no extra `done_o`. The bench provokes this by issuing the next start in the done cycle on every third transaction. It then judges both transactions by the rising-edge count, the setup and hold widths, and the readback, which must equal the settings just written.

// File: rtl/pot_chain_pkg.sv
package pot_chain_pkg;

    localparam int FRAME_BITS = 17;
    localparam int CODE_BITS  = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_HOLD  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/pot_half_timer.sv
// Counts system cycles of one serial half period while the sequencer runs.
module pot_half_timer #(
    parameter int HALF = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pot_seq_fsm.sv
// Sequencer: setup, clock high/low phases, hold, done.
module pot_seq_fsm
    import pot_chain_pkg::*;
#(
    parameter int TOTAL_BITS = 68
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic load,
    output logic shift,
    output logic capture,
    output logic busy,
    output logic ser_en,
    output logic ser_clk,
    output logic done
);
    localparam int CNT_W = $clog2(TOTAL_BITS + 1);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [CNT_W-1:0] rise_q;
    logic             all_sent;

    assign all_sent = (rise_q == CNT_W'(TOTAL_BITS));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SETUP;
            ST_SETUP: if (tick)  state_d = ST_HIGH;
            ST_HIGH:  if (tick)  state_d = all_sent ? ST_HOLD : ST_LOW;
            ST_LOW:   if (tick)  state_d = ST_HIGH;
            ST_HOLD:  if (tick)  state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign load    = (state_q == ST_IDLE) && start;
    assign capture = tick && ((state_q == ST_SETUP) || (state_q == ST_LOW));
    assign shift   = tick && (state_q == ST_HIGH) && !all_sent;

    // registered outputs and rise counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_en  <= 1'b0;
            ser_clk <= 1'b0;
            done    <= 1'b0;
            rise_q  <= '0;
        end else begin
            ser_en  <= (state_d != ST_IDLE);
            ser_clk <= (state_d == ST_HIGH);
            done    <= (state_q == ST_HOLD) && tick;
            if (load) begin
                rise_q <= '0;
            end else if (capture) begin
                rise_q <= rise_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pot_shift_path.sv
// Outgoing and returning shift registers for the whole chain.
module pot_shift_path #(
    parameter int TOTAL_BITS = 68
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  shift,
    input  logic                  capture,
    input  logic [TOTAL_BITS-1:0] load_data,
    input  logic                  ret_bit,
    output logic                  out_bit,
    output logic [TOTAL_BITS-1:0] rx_data
);
    logic [TOTAL_BITS-1:0] tx_q;
    logic [TOTAL_BITS-1:0] rx_q;

    assign out_bit = tx_q[TOTAL_BITS-1];
    assign rx_data = rx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
        end else if (shift) begin
            tx_q <= {tx_q[TOTAL_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (capture) begin
            rx_q <= {rx_q[TOTAL_BITS-2:0], ret_bit};
        end
    end
endmodule

// File: rtl/chain_pot_writer.sv
module chain_pot_writer
    import pot_chain_pkg::*;
#(
    parameter int NUM_DEV     = 4,
    parameter int CLK_HZ      = 125_000_000,
    parameter int MAX_SCLK_HZ = 10_000_000,
    parameter int DIV_RATIO   = 14
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic [NUM_DEV*FRAME_BITS-1:0]   cfg_i,
    output logic                            busy_o,
    output logic                            done_o,
    output logic [NUM_DEV*FRAME_BITS-1:0]   rdback_o,
    output logic                            sen_o,
    output logic                            sclk_o,
    output logic                            sdat_o,
    input  logic                            sret_i
);
    localparam int TOTAL_BITS = NUM_DEV * FRAME_BITS;
    localparam int HALF       = DIV_RATIO / 2;

    // R5: elaboration-time rate and ratio checks
    if ((DIV_RATIO < 2) || ((DIV_RATIO % 2) != 0)) begin : g_bad_ratio
        $error("DIV_RATIO must be even and at least 2");
    end
    if (longint'(CLK_HZ) > longint'(MAX_SCLK_HZ) * longint'(DIV_RATIO)) begin : g_too_fast
        $error("serial clock would exceed MAX_SCLK_HZ");
    end

    logic tick;
    logic load;
    logic shift;
    logic capture;
    logic out_bit;

    pot_half_timer #(
        .HALF (HALF)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_o),
        .tick  (tick)
    );

    pot_seq_fsm #(
        .TOTAL_BITS (TOTAL_BITS)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .tick    (tick),
        .load    (load),
        .shift   (shift),
        .capture (capture),
        .busy    (busy_o),
        .ser_en  (sen_o),
        .ser_clk (sclk_o),
        .done    (done_o)
    );

    pot_shift_path #(
        .TOTAL_BITS (TOTAL_BITS)
    ) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shift     (shift),
        .capture   (capture),
        .load_data (cfg_i),
        .ret_bit   (sret_i),
        .out_bit   (out_bit),
        .rx_data   (rdback_o)
    );

    assign sdat_o = sen_o & out_bit;
endmodule

// File: rtl/chain_pot_writer_chk.sv
module chain_pot_writer_chk #(
    parameter int NUM_DEV   = 4,
    parameter int DIV_RATIO = 14
) (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic sen_o,
    input logic sclk_o,
    input logic sdat_o
);
    localparam int TOTAL = NUM_DEV * 17;
    localparam int HALF  = DIV_RATIO / 2;

    logic        clk_q;
    logic [15:0] edge_cnt;
    logic [15:0] since_en;
    logic [15:0] hi_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q    <= 1'b0;
            edge_cnt <= '0;
            since_en <= '0;
            hi_len   <= '0;
        end else begin
            clk_q <= sclk_o;
            if (!sen_o) begin
                edge_cnt <= '0;
            end else if (sclk_o && !clk_q) begin
                edge_cnt <= edge_cnt + 16'd1;
            end
            if (!sen_o) begin
                since_en <= '0;
            end else if (since_en != 16'hFFFF) begin
                since_en <= since_en + 16'd1;
            end
            if (!sclk_o) begin
                hi_len <= '0;
            end else if (hi_len != 16'hFFFF) begin
                hi_len <= hi_len + 16'd1;
            end
        end
    end

    assert_whole_frames_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sen_o) |-> (edge_cnt == 16'(TOTAL)));

    assert_dat_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sen_o && $past(sen_o) && !$fell(sclk_o)) |-> $stable(sdat_o));

    assert_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (hi_len == 16'(HALF)));

    assert_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk_o) && (edge_cnt == 16'd0)) |-> (since_en >= 16'(HALF)));

    assert_clk_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sen_o |-> !sclk_o);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sen_o) |-> (done_o && !busy_o));

    assert_busy_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sen_o |-> busy_o);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sen_o && !sdat_o));
endmodule

bind chain_pot_writer chain_pot_writer_chk #(
    .NUM_DEV   (NUM_DEV),
    .DIV_RATIO (DIV_RATIO)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_o (busy_o),
    .done_o (done_o),
    .sen_o  (sen_o),
    .sclk_o (sclk_o),
    .sdat_o (sdat_o)
);

// File: tb/sim_chain_pot_writer.sv
module sim_chain_pot_writer;
    localparam int NDEV = 2;
    localparam int DIV  = 14;
    localparam int HALF = DIV / 2;
    localparam int TOT  = NDEV * 17;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [TOT-1:0] cfg_i = '0;
    logic           busy_o, done_o, sen_o, sclk_o, sdat_o, sret_i;
    logic [TOT-1:0] rdback_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    chain_pot_writer #(
        .NUM_DEV     (NDEV),
        .CLK_HZ      (125_000_000),
        .MAX_SCLK_HZ (10_000_000),
        .DIV_RATIO   (DIV)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
        .busy_o(busy_o), .done_o(done_o), .rdback_o(rdback_o),
        .sen_o(sen_o), .sclk_o(sclk_o), .sdat_o(sdat_o), .sret_i(sret_i)
    );

    // chain model: device 0 nearest the writer, device k in bits [17k+16:17k]
    logic [TOT-1:0] chain_q = 34'h2A5C396E1;
    assign sret_i = chain_q[TOT-1];
    always @(posedge sclk_o) if (sen_o) chain_q <= {chain_q[TOT-2:0], sdat_o};

    // wire monitor, sampled at the falling system clock edge
    logic           m_en_q = 0, m_clk_q = 0, m_dat_q = 0;
    int             m_rises, m_since, m_setup, m_run, m_tail;
    bit             m_bad_w, m_dat_bad, m_end_ok, m_busy_bad, m_idle_clk;
    logic [TOT-1:0] m_stream;

    always @(negedge clk) begin
        if (sen_o && !m_en_q) begin
            m_rises = 0; m_since = 0; m_setup = -1; m_run = 0; m_tail = 0;
            m_bad_w = 0; m_dat_bad = 0; m_end_ok = 0; m_busy_bad = 0;
            m_stream = '0;
        end else if (sen_o) begin
            m_since++;
        end
        if (sen_o) begin
            if (!busy_o) m_busy_bad = 1;
            if (sclk_o != m_clk_q) begin
                if (sclk_o) begin
                    if (m_rises == 0) m_setup = m_since;
                    else if (m_run != HALF) m_bad_w = 1;
                    m_rises++;
                    m_stream = {m_stream[TOT-2:0], sdat_o};
                end else begin
                    if (m_run != HALF) m_bad_w = 1;
                    m_tail = 0;
                end
                m_run = 1;
            end else begin
                m_run++;
            end
            if (sclk_o && m_clk_q && sdat_o != m_dat_q) m_dat_bad = 1;
            if (!sclk_o) m_tail++;
        end else begin
            if (sclk_o) m_idle_clk = 1;
            if (m_en_q) m_end_ok = done_o && !busy_o;
        end
        m_en_q  = sen_o;
        m_clk_q = sclk_o;
        m_dat_q = sdat_o;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [TOT-1:0] make_cfg(input int j);
        logic [TOT-1:0] v = '0;
        if (j == 1) v = '1;
        else if (j >= 2 && j < 2 + TOT) v = TOT'(1) << (j - 2);
        else if (j >= 2 + TOT) begin
            for (int k = 0; k < NDEV; k++) begin
                v[k*17+16]    = 1'(j + k);
                v[k*17+8 +: 8] = 8'(j * 37 + k * 91);
                v[k*17 +: 8]   = 8'(j * j + 5 * k + 3);
            end
        end
        return v;
    endfunction

    task automatic do_txn(input int j, input bit b2b);
        logic [TOT-1:0] expv = make_cfg(j);
        logic [TOT-1:0] old  = chain_q;
        if (!b2b) begin
            tick();
            chk(done_o == 1'b0, "R7", "done single pulse", 64'(done_o), 64'd0);
            tick(); tick();
        end
        cfg_i = expv; start_i = 1'b1;
        tick();
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R7", "busy after start", 64'(busy_o), 64'd1);
        chk(done_o == 1'b0, "R7", "no done after start", 64'(done_o), 64'd0);
        if (j % 5 == 2) begin
            repeat (60) tick();
            cfg_i = ~expv; start_i = 1'b1;   // R7: must be ignored
            tick();
            start_i = 1'b0;
        end
        while (!done_o) tick();
        chk(chain_q == expv, "R2", "chain contents", 64'(chain_q), 64'(expv));
        chk(m_stream == expv, "R2", "wire order", 64'(m_stream), 64'(expv));
        for (int k = 0; k < NDEV; k++) begin
            chk(chain_q[k*17+16] == expv[k*17+16], "R1", "stack select",
                64'(chain_q[k*17+16]), 64'(expv[k*17+16]));
            chk(chain_q[k*17+8 +: 8] == expv[k*17+8 +: 8], "R1", "wiper1 code",
                64'(chain_q[k*17+8 +: 8]), 64'(expv[k*17+8 +: 8]));
            chk(chain_q[k*17 +: 8] == expv[k*17 +: 8], "R1", "wiper0 code",
                64'(chain_q[k*17 +: 8]), 64'(expv[k*17 +: 8]));
        end
        chk(rdback_o == old, "R8", "readback", 64'(rdback_o), 64'(old));
        chk(m_rises == TOT, "R3", "rising edges", 64'(m_rises), 64'(TOT));
        chk(m_dat_bad == 0, "R4", "data stable in high phase", 64'(m_dat_bad), 64'd0);
        chk(m_bad_w == 0, "R5", "phase widths", 64'(m_bad_w), 64'd0);
        chk(m_setup == HALF, "R6", "setup cycles", 64'(m_setup), 64'(HALF));
        chk(m_tail == HALF, "R6", "hold cycles", 64'(m_tail), 64'(HALF));
        chk(m_idle_clk == 0, "R6", "clock low while disabled", 64'(m_idle_clk), 64'd0);
        chk(m_end_ok == 1, "R7", "done with enable fall", 64'(m_end_ok), 64'd1);
        chk(m_busy_bad == 0, "R7", "busy during enable", 64'(m_busy_bad), 64'd0);
    endtask

    initial begin
        m_idle_clk = 0;
        tick(); tick();
        chk({sen_o, sclk_o, sdat_o, busy_o, done_o} == 5'b0, "R9", "outputs in reset",
            64'({sen_o, sclk_o, sdat_o, busy_o, done_o}), 64'd0);
        rst_n = 1'b1;
        repeat (3) tick();
        chk({sen_o, sclk_o, sdat_o, busy_o, done_o} == 5'b0, "R9", "outputs idle",
            64'({sen_o, sclk_o, sdat_o, busy_o, done_o}), 64'd0);
        chk(rdback_o == '0, "R9", "readback after reset", 64'(rdback_o), 64'd0);
        for (int j = 0; j < 2 + TOT + 12; j++) begin
            do_txn(j, (j % 3 == 1));
        end
        tick();
        chk(done_o == 1'b0 && busy_o == 1'b0, "R7", "final idle",
            64'({done_o, busy_o}), 64'd0);
        summary();
        $finish;
    end
endmodule